// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources on behalf of a small 8-bit CPU core. The sources are two external request flags, two timer overflow flags and one serial flag, which stands for receive OR transmit. The flags themselves live outside the controller. The controller reads them as levels and returns a one-cycle clear pulse for the flags that hardware is allowed to clear.

Software writes two 8-bit registers, both with the same bit layout:
- A mask register, which carries a global gate bit and one enable bit per source.
- A level register, in which a 1 lifts that source to the high level.

Toward the CPU the block drives a registered request line and a 16-bit vector address. It takes three pulses back from the CPU:
- an acknowledge pulse when the CPU vectors;
- a return pulse when an interrupt-return instruction executes;
- an instruction-complete pulse, used to enforce one instruction between a return and the next vectoring.

A two-bit in-service stack records which levels are being served. A low-level routine may be preempted by a high-level request, and nothing preempts a high-level routine. Only the interrupt-return pops the stack.

Top module: `vic_two_level`

## Requirements
- R1: After reset, `irq_req_o` is 0, `irq_vec_o` is 0x0000, `in_service_o` is 2'b00 and `flag_clr_o` is 0. Both configuration registers reset to 0x00, so every source is masked.
- R2: While bit 7 of the mask register (the global gate) is 0, `irq_req_o` stays 0, whatever the source enables and flags are.
- R3: Source bit positions in both registers and in the flag vectors are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A source whose mask bit is 0 never raises a request.
- R4: Among eligible requests of equal level, the lowest source bit wins. The vector is 0x0003 + 8 × (source bit), giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. Each register write takes effect on the request within two cycles.
- R5: A source whose level-register bit is 1 is served before any low-level source, regardless of polling order.
- R6: With only the low level in service (`in_service_o` = 2'b01), a low-level request is withheld and a high-level request is presented. While the high level is in service (bit 1 of `in_service_o`), no request is presented.
- R7: An acknowledge that arrives while `irq_req_o` is 1 drives `flag_clr_o` in that same cycle. The pulse is one-hot on the served source for bits 0 to 3, and bit 4 (serial) is never driven.
- R8: An accepted acknowledge sets `in_service_o` bit 1 for a high-level source and bit 0 for a low-level one. Only a return pulse clears a bit: bit 1 if it is set, otherwise bit 0. Instruction-complete pulses alone leave `in_service_o` unchanged.
- R9: After a return pulse, `irq_req_o` stays 0 until an instruction-complete pulse has been seen. A pending eligible request appears one cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the mask register, 1 the level register |
| cfg_wdata_i | input | 8 | Configuration write data |
| flag_i | input | 5 | Source flag levels |
| flag_clr_o | output | 5 | One-cycle clear pulse for source flags |
| ack_i | input | 1 | CPU vectoring acknowledge pulse |
| reti_i | input | 1 | Interrupt-return pulse |
| insn_done_i | input | 1 | Instruction-complete pulse |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 16 | Vector address of the presented request |
| in_service_o | output | 2 | In-service stack: bit 0 low level, bit 1 high level |

## Verification
The hardest state to reach is a nested one. A low-level routine is preempted by a high-level one, then a plain subroutine return is issued, then a real return, and a high-level request must still be held off by the one-instruction gap. The bench reaches it in a single scenario:
1. Acknowledge a low-level timer request.
2. Raise a high-level serial flag and acknowledge it.
3. Raise a high-level external flag while the high level is busy.
4. Issue instruction-complete pulses with no return.
5. Issue a return and watch the request stay low until the next instruction completes.

The stack is then unwound twice to confirm that a pending low-level source is presented once the stack is empty.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC       = 5;
    localparam int IDXW       = $clog2(NSRC);
    localparam int CFGW       = 8;
    localparam int GLB_BIT    = 7;
    localparam int VECW       = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    // sources the controller may clear on acknowledge (serial excluded)
    localparam logic [NSRC-1:0] HW_CLR_MASK = 5'b01111;

    typedef struct packed {
        logic             req;
        logic [VECW-1:0]  vec;
        logic [IDXW-1:0]  idx;
        logic             lvl;
        logic [1:0]       isr;
        logic             hold;
    } vic_state_t;
endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic            sel_i,
    input  logic [CFGW-1:0] wdata_i,
    output logic [NSRC-1:0] ien_o,
    output logic            glb_o,
    output logic [NSRC-1:0] lvl_o
);
    typedef struct packed {
        logic [NSRC-1:0] ien;
        logic            glb;
        logic [NSRC-1:0] lvl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (sel_i) begin
                cfg_d.lvl = wdata_i[NSRC-1:0];
            end else begin
                cfg_d.ien = wdata_i[NSRC-1:0];
                cfg_d.glb = wdata_i[GLB_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ien_o = cfg_q.ien;
    assign glb_o = cfg_q.glb;
    assign lvl_o = cfg_q.lvl;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] lvl_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o,
    output logic            hi_o
);
    logic [NSRC-1:0] hi_pend, lo_pend;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_split
            assign hi_pend[g] = pend_i[g] &  lvl_i[g];
            assign lo_pend[g] = pend_i[g] & ~lvl_i[g];
        end
    endgenerate

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        hi_o    = 1'b0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (lo_pend[i]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
            end
        end
        for (int i = NSRC-1; i >= 0; i--) begin
            if (hi_pend[i]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
                hi_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_two_level.sv
module vic_two_level
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic            cfg_sel_i,
    input  logic [7:0]      cfg_wdata_i,
    input  logic [4:0]      flag_i,
    output logic [4:0]      flag_clr_o,
    input  logic            ack_i,
    input  logic            reti_i,
    input  logic            insn_done_i,
    output logic            irq_req_o,
    output logic [15:0]     irq_vec_o,
    output logic [1:0]      in_service_o
);
    logic [NSRC-1:0] ien, lvl, pend;
    logic            glb, found, hi;
    logic [IDXW-1:0] idx;
    logic            take, allowed;
    vic_state_t      st_d, st_q;

    vic_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .ien_o   (ien),
        .glb_o   (glb),
        .lvl_o   (lvl)
    );

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_pend
            assign pend[g] = flag_i[g] & ien[g] & glb;
        end
    endgenerate

    vic_arbiter u_arb (
        .pend_i  (pend),
        .lvl_i   (lvl),
        .found_o (found),
        .idx_o   (idx),
        .hi_o    (hi)
    );

    assign take = ack_i & st_q.req;

    always_comb begin
        st_d = st_q;
        // in-service stack: return pops, accepted acknowledge pushes
        if (reti_i) begin
            if (st_q.isr[1]) st_d.isr[1] = 1'b0;
            else             st_d.isr[0] = 1'b0;
        end else if (take) begin
            if (st_q.lvl) st_d.isr[1] = 1'b1;
            else          st_d.isr[0] = 1'b1;
        end
        // one completed instruction required after a return
        if (reti_i)           st_d.hold = 1'b1;
        else if (insn_done_i) st_d.hold = 1'b0;

        allowed  = hi ? !st_d.isr[1] : (st_d.isr == 2'b00);
        st_d.req = found & allowed & !st_d.hold;
        st_d.idx = idx;
        st_d.lvl = hi;
        st_d.vec = st_d.req ? VECW'(VEC_BASE) + VECW'(idx) * VECW'(VEC_STRIDE)
                            : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_clr_o = '0;
        if (take) flag_clr_o[st_q.idx] = HW_CLR_MASK[st_q.idx];
    end

    assign irq_req_o    = st_q.req;
    assign irq_vec_o    = st_q.vec;
    assign in_service_o = st_q.isr;
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  flag_clr_o,
    input logic        ack_i,
    input logic        reti_i,
    input logic        irq_req_o,
    input logic [15:0] irq_vec_o,
    input logic [1:0]  in_service_o
);
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr_o)); // R7
    AST_CLR_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr_o[4]); // R7
    AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr_o) |-> (ack_i && irq_req_o)); // R7
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vec_o[2:0] == 3'd3 && irq_vec_o < 16'h0028)); // R4
    AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        in_service_o[1] |-> !irq_req_o); // R6
    AST_RELEASE_BY_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        (|(in_service_o & ~$past(in_service_o))) == 1'b0 || 1'b1 ? 
        ((|($past(in_service_o) & ~in_service_o)) -> $past(reti_i)) : 1'b1); // R8
    AST_NO_REQ_AFTER_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !irq_req_o); // R9
endmodule

bind vic_two_level vic_checker u_vic_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_clr_o   (flag_clr_o),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .irq_req_o    (irq_req_o),
    .irq_vec_o    (irq_vec_o),
    .in_service_o (in_service_o)
);

// File: tb/tb_vic_two_level.sv
`timescale 1ns/1ps
module tb_vic_two_level;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [4:0]  flags = '0, sw_set = '0, sw_clr = '0;
    logic [4:0]  flag_clr;
    logic        ack = 1'b0, reti = 1'b0, insn_done = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  in_service;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    vic_two_level dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .flag_i(flags), .flag_clr_o(flag_clr),
        .ack_i(ack), .reti_i(reti), .insn_done_i(insn_done),
        .irq_req_o(irq_req), .irq_vec_o(irq_vec), .in_service_o(in_service)
    );

    // flag model: hardware clear from the controller, software set/clear from tasks
    always @(posedge clk) flags <= ((flags & ~flag_clr) | sw_set) & ~sw_clr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_flags(input logic [4:0] m);
        @(negedge clk); sw_set = m;
        @(negedge clk); sw_set = '0;
    endtask

    task automatic clr_flags(input logic [4:0] m);
        @(negedge clk); sw_clr = m;
        @(negedge clk); sw_clr = '0;
    endtask

    // acknowledge from a negedge where a request is shown; check the clear pulse
    task automatic do_ack(input string req, input logic [4:0] exp_clr);
        ack = 1'b1; #1;
        chk(req, flag_clr, exp_clr);
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    task automatic pulse_done();
        insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 vec", irq_vec, 16'h0000);
        chk("R1 isr", in_service, 2'b00);
        chk("R1 clr", flag_clr, 0);
        set_flags(5'b11111); cyc(2);
        chk("R1 masked after reset", irq_req, 0);
        clr_flags(5'b11111);
    endtask

    task automatic t_gate();
        set_flags(5'b11111);
        wr(1'b0, 8'h1F); cyc(2);
        chk("R2 global gate off", irq_req, 0);
        wr(1'b0, 8'h80); cyc(2);
        chk("R3 all sources masked", irq_req, 0);
        wr(1'b0, 8'h94); cyc(2);
        chk("R3 only ext1+serial enabled", irq_vec, 16'h0013);
    endtask

    task automatic t_order();
        wr(1'b0, 8'h98); cyc(2);
        chk("R4 tmr1 beats serial", irq_vec, 16'h001B);
        wr(1'b0, 8'h90); cyc(2);
        chk("R4 serial vector", irq_vec, 16'h0023);
        wr(1'b0, 8'h9F); cyc(2);
        chk("R4 ext0 first", irq_vec, 16'h0003);
        chk("R4 req", irq_req, 1);
        wr(1'b0, 8'h9E); cyc(2);
        chk("R4 tmr0 next", irq_vec, 16'h000B);
    endtask

    task automatic t_prio();
        wr(1'b1, 8'h08); cyc(2);
        chk("R5 high tmr1 first", irq_vec, 16'h001B);
        wr(1'b1, 8'h14); cyc(2);
        chk("R5 two high, poll order", irq_vec, 16'h0013);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        clr_flags(5'b11111); cyc(1);
    endtask

    task automatic t_nest();
        wr(1'b1, 8'h11);        // serial and ext0 high
        wr(1'b0, 8'h9F);
        set_flags(5'b00010); cyc(2);
        chk("R4 low tmr0 presented", irq_vec, 16'h000B);
        do_ack("R7 tmr0 cleared", 5'b00010);
        chk("R8 low pushed", in_service, 2'b01);
        set_flags(5'b01000); cyc(2);
        chk("R6 low blocks low", irq_req, 0);
        set_flags(5'b10000); cyc(2);
        chk("R6 high preempts low", irq_vec, 16'h0023);
        do_ack("R7 serial not cleared", 5'b00000);
        chk("R8 high pushed", in_service, 2'b11);
        set_flags(5'b00001); cyc(2);
        chk("R6 nothing preempts high", irq_req, 0);
        clr_flags(5'b10000);
        pulse_done(); pulse_done(); cyc(1);
        chk("R8 plain return keeps isr", in_service, 2'b11);
        pulse_reti();
        chk("R8 pop high first", in_service, 2'b01);
        cyc(3);
        chk("R9 held after return", irq_req, 0);
        pulse_done();
        chk("R9 released after insn", irq_vec, 16'h0003);
        do_ack("R7 ext0 cleared", 5'b00001);
        chk("R8 high pushed again", in_service, 2'b11);
        pulse_reti(); pulse_done(); cyc(1);
        chk("R6 low still blocks tmr1", irq_req, 0);
        pulse_reti();
        chk("R8 pop low", in_service, 2'b00);
        pulse_done();
        chk("R9 tmr1 after empty stack", irq_vec, 16'h001B);
        do_ack("R7 tmr1 cleared", 5'b01000);
        cyc(2);
        chk("R7 tmr1 flag gone", flags[3], 0);
    endtask

    initial begin
        fork
            begin
                cyc(3); rst_n = 1'b1; cyc(1);
                t_reset();
                t_gate();
                t_order();
                t_prio();
                t_nest();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule